// File: doc/BRIEF.md
# Re-Reference Interval Replacement Engine

This block holds the replacement state for every set of an N-way set-associative cache and picks the way to evict when a set needs a new line. Each way of each set has a small saturating counter. The counter predicts how soon the line will be used again: 0 means soon, and the all-ones value means distant. A hit pulls that way's counter down to 0. A fill request starts a search in one set for a way whose counter is at the maximum.

While no way in the set is at the maximum, the engine ages the whole set by one step per clock and tries again. The chosen way is reported with a one-cycle done pulse, and its counter is loaded with max-1 for the incoming line. With a counter width of 1, the engine works as a plain not-recently-used scheme. The cache controller owns the tags, data and miss handling. It issues a hit update or a fill request in any cycle in which the engine is not busy.

Top module: `rrip_engine`

## Requirements
- R1: Reset loads every counter with the maximum value 2^CW-1 and clears busy and done, so the first fill in an untouched set returns way 0 after one search cycle.
- R2: A hit request (req_valid_i=1, req_hit_i=1) accepted while idle sets the counter of way req_way_i in set req_set_i to 0, effective from the next cycle.
- R3: A search picks the lowest-numbered way of the set whose counter equals the maximum.
- R4: If no way of the set is at the maximum, every counter of that set increases by exactly one in that cycle, busy stays high, and the search repeats in the next cycle. No counter ever wraps.
- R5: The chosen victim's counter is set to max-1 in the cycle the victim is reported.
- R6: A fill request (req_valid_i=1, req_hit_i=0) accepted while idle raises busy_o from the next cycle. In the cycle after a successful search step, done_o is high for exactly one cycle, victim_o shows the chosen way, and busy_o is low. victim_o holds its value until the next done.
- R7: Any request presented while busy_o is high is ignored. It changes no counter and does not restart or redirect the search.
- R8: With CW=1, the engine behaves as not-recently-used: a hit clears the way's bit, a fill evicts the lowest way whose bit is 1 and leaves that bit at 0, and if no bit is 1, one aging step sets all bits of the set to 1.
- R9: The counters of each set change only through requests for that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_hit_i | input | 1 | 1 = hit update, 0 = fill (victim search) |
| req_set_i | input | $clog2(SETS) | Set addressed by the request |
| req_way_i | input | $clog2(WAYS) | Way that hit (hit requests only) |
| busy_o | output | 1 | Victim search in progress |
| done_o | output | 1 | One-cycle pulse: victim_o is valid |
| victim_o | output | $clog2(WAYS) | Chosen victim way |

## Verification
Fills are first applied to a fresh set, so that the reset value and the lowest-index choice are visible. A set is then filled way by way until every counter sits at max-1, which forces a single aging step. Next, every way of a set is hit before a fill, which forces the longest aging run and separates a per-cycle increment from a jump to the maximum. Hits and fills aimed at other sets during a search show whether busy-time requests leak into the state. A pseudo-random mix of hits and fills is then compared cycle by cycle with a behavioural model on both the default counter width and a 1-bit, 4-way instance.

// File: rtl/rrip_pkg.sv
package rrip_pkg;
    typedef enum logic [1:0] {
        CTR_NOP   = 2'd0,
        CTR_CLEAR = 2'd1,
        CTR_FILL  = 2'd2,
        CTR_AGE   = 2'd3
    } ctr_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SEARCH = 1'b1
    } eng_st_e;
endpackage

// File: rtl/rrip_ctr_array.sv
module rrip_ctr_array
    import rrip_pkg::*;
#(
    parameter int WAYS = 8,
    parameter int SETS = 64,
    parameter int CW   = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  ctr_op_e                   op_i,
    input  logic [SET_W-1:0]          set_i,
    input  logic [WAY_W-1:0]          way_i,
    output logic [WAYS-1:0][CW-1:0]   rd_o
);
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};
    localparam logic [CW-1:0] NEWV = MAXV - CW'(1);

    logic [CW-1:0] ctr_q [SETS][WAYS];
    logic [CW-1:0] ctr_d [SETS][WAYS];
    logic [WAYS-1:0] at_max;

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_o[w]   = ctr_q[set_i][w];
        assign at_max[w] = (ctr_q[set_i][w] == MAXV);
    end

    always_comb begin
        ctr_d = ctr_q;
        case (op_i)
            CTR_CLEAR: ctr_d[set_i][way_i] = '0;
            CTR_FILL:  ctr_d[set_i][way_i] = NEWV;
            CTR_AGE: begin
                for (int w = 0; w < WAYS; w++) begin
                    ctr_d[set_i][w] = ctr_q[set_i][w] + CW'(1);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    ctr_q[s][w] <= MAXV;
                end
            end
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == CTR_CLEAR) |=> (ctr_q[$past(set_i)][$past(way_i)] == '0));

    assert_fill_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == CTR_FILL) |=> (ctr_q[$past(set_i)][$past(way_i)] == NEWV));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == CTR_AGE) |-> (at_max == '0));
endmodule

// File: rtl/rrip_victim_pick.sv
module rrip_victim_pick #(
    parameter int WAYS = 8,
    parameter int CW   = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [WAYS-1:0][CW-1:0]  ctr_i,
    output logic                     found_o,
    output logic [WAY_W-1:0]         way_o
);
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};

    always_comb begin
        found_o = 1'b0;
        way_o   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (ctr_i[w] == MAXV) begin
                found_o = 1'b1;
                way_o   = WAY_W'(w);
            end
        end
    end

    assert_pick_is_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> (ctr_i[way_o] == MAXV));

    assert_none_missed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !found_o |-> (ctr_i[0] != MAXV));
endmodule

// File: rtl/rrip_engine.sv
module rrip_engine
    import rrip_pkg::*;
#(
    parameter int WAYS = 8,
    parameter int SETS = 64,
    parameter int CW   = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic             req_hit_i,
    input  logic [SET_W-1:0] req_set_i,
    input  logic [WAY_W-1:0] req_way_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WAY_W-1:0] victim_o
);
    typedef struct packed {
        eng_st_e          st;
        logic [SET_W-1:0] set;
        logic             done;
        logic [WAY_W-1:0] victim;
    } eng_state_t;

    eng_state_t s_d, s_q;

    ctr_op_e                  op;
    logic [SET_W-1:0]         op_set;
    logic [WAY_W-1:0]         op_way;
    logic [WAYS-1:0][CW-1:0]  set_ctrs;
    logic                     pick_found;
    logic [WAY_W-1:0]         pick_way;

    rrip_ctr_array #(.WAYS(WAYS), .SETS(SETS), .CW(CW)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .op_i  (op),
        .set_i (op_set),
        .way_i (op_way),
        .rd_o  (set_ctrs)
    );

    rrip_victim_pick #(.WAYS(WAYS), .CW(CW)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctr_i   (set_ctrs),
        .found_o (pick_found),
        .way_o   (pick_way)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        op       = CTR_NOP;
        op_set   = s_q.set;
        op_way   = pick_way;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    if (req_hit_i) begin
                        op     = CTR_CLEAR;
                        op_set = req_set_i;
                        op_way = req_way_i;
                    end else begin
                        s_d.st  = ST_SEARCH;
                        s_d.set = req_set_i;
                    end
                end
            end
            ST_SEARCH: begin
                if (pick_found) begin
                    op         = CTR_FILL;
                    s_d.done   = 1'b1;
                    s_d.victim = pick_way;
                    s_d.st     = ST_IDLE;
                end else begin
                    op = CTR_AGE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, set: '0, done: 1'b0, victim: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o   = (s_q.st == ST_SEARCH);
    assign done_o   = s_q.done;
    assign victim_o = s_q.victim;

    assert_done_after_search_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && !busy_o));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_victim_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> (done_o || $stable(victim_o)));

    assert_busy_ignores_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && req_valid_i && req_hit_i) |-> (op != CTR_CLEAR));
endmodule

// File: tb/sim_rrip_engine.sv
module ref_rrip #(
    parameter int W = 8,
    parameter int S = 64,
    parameter int C = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_hit,
    input  int   req_set,
    input  int   req_way,
    output int   busy,
    output int   done,
    output int   victim
);
    int ctr [S][W];
    int cs;
    int v;
    int mx;
    assign mx = (1 << C) - 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < S; s++) for (int w = 0; w < W; w++) ctr[s][w] = mx;
            busy = 0; done = 0; victim = 0; cs = 0;
        end else begin
            done = 0;
            if (busy != 0) begin
                v = -1;
                for (int w = W - 1; w >= 0; w--) if (ctr[cs][w] == mx) v = w;
                if (v >= 0) begin
                    ctr[cs][v] = mx - 1; done = 1; victim = v; busy = 0;
                end else begin
                    for (int w = 0; w < W; w++) ctr[cs][w] = ctr[cs][w] + 1;
                end
            end else if (req_valid) begin
                if (req_hit) ctr[req_set][req_way] = 0;
                else begin busy = 1; cs = req_set; end
            end
        end
    end
endmodule

module sim_rrip_engine;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_hit = 1'b0;
    logic [5:0] req_set = '0;
    logic [2:0] req_way = '0;

    logic busy0, done0, busy1, done1;
    logic [2:0] vic0;
    logic [1:0] vic1;
    int mb0, md0, mv0, mb1, md1, mv1;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit cmp_en = 1'b0;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    rrip_engine u0 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_hit_i(req_hit),
        .req_set_i(req_set), .req_way_i(req_way),
        .busy_o(busy0), .done_o(done0), .victim_o(vic0)
    );

    rrip_engine #(.WAYS(4), .SETS(4), .CW(1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_hit_i(req_hit),
        .req_set_i(req_set[1:0]), .req_way_i(req_way[1:0]),
        .busy_o(busy1), .done_o(done1), .victim_o(vic1)
    );

    ref_rrip #(.W(8), .S(64), .C(2)) m0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hit(req_hit),
        .req_set(int'(req_set)), .req_way(int'(req_way)),
        .busy(mb0), .done(md0), .victim(mv0)
    );

    ref_rrip #(.W(4), .S(4), .C(1)) m1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hit(req_hit),
        .req_set(int'(req_set[1:0])), .req_way(int'(req_way[1:0])),
        .busy(mb1), .done(md1), .victim(mv1)
    );

    task automatic check(string t, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", t, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            check(tag, "u0 busy", int'(busy0), mb0);
            check(tag, "u0 done", int'(done0), md0);
            check(tag, "u0 victim", int'(vic0), mv0);
            check("R8", "u1 busy", int'(busy1), mb1);
            check("R8", "u1 done", int'(done1), md1);
            check("R8", "u1 victim", int'(vic1), mv1);
        end
    end

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL R6 watchdog actual=%0d expected<=150000", cycles);
            finish_run();
        end
    end

    task automatic issue(bit h, int s, int w);
        @(negedge clk);
        req_valid = 1'b1; req_hit = h; req_set = 6'(s); req_way = 3'(w);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy0 || busy1) @(negedge clk);
    endtask

    task automatic fill_expect(int s, int exp_way, string t);
        tag = t;
        issue(1'b0, s, 0);
        wait_idle();
        check(t, "victim direct", int'(vic0), exp_way);
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);
        // R1: reset state and first fill in an untouched set
        check("R1", "busy after reset", int'(busy0), 0);
        check("R1", "done after reset", int'(done0), 0);
        fill_expect(5, 0, "R1");
        // R3 / R5: successive fills walk ways 1..7 (each filled way left at 2)
        for (int w = 1; w < 8; w++) fill_expect(5, w, "R3");
        // R4: all at max-1 -> one aging step, then way 0
        fill_expect(5, 0, "R4");
        // R2: hit clears way 3; after fills, way 3 is found last
        tag = "R2";
        issue(1'b1, 5, 3);
        // R9: a different set is untouched and offers way 0
        fill_expect(9, 0, "R9");
        // R4: every way of set 7 hit -> longest aging run
        tag = "R4";
        for (int w = 0; w < 8; w++) issue(1'b1, 7, w);
        fill_expect(7, 0, "R4");
        // R7: requests during a search are ignored
        tag = "R7";
        for (int w = 0; w < 8; w++) issue(1'b1, 20, w);
        @(negedge clk);
        req_valid = 1'b1; req_hit = 1'b0; req_set = 6'd20; req_way = 3'd0;
        @(negedge clk);
        req_hit = 1'b1; req_set = 6'd21; req_way = 3'd0;
        @(negedge clk);
        req_hit = 1'b0; req_set = 6'd22;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        check("R7", "victim set20", int'(vic0), 0);
        fill_expect(21, 0, "R7");
        // R6: pseudo-random mix
        tag = "R6";
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            issue(lfsr[0] | lfsr[1], int'(lfsr[4:2]) + 8, int'(lfsr[7:5]));
            if (lfsr[8]) wait_idle();
        end
        wait_idle();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule